// File: doc/BRIEF.md
# Two-Bank Flash Read Prefetch Controller

This block stands between a 32-bit processor read port and a flash array made of two banks that each return 128 bits per access. Consecutive 16-byte blocks alternate between the two banks. One access to both banks at the same row gives a 256-bit line, which is held in a single prefetch line. A read that falls in the held line is answered on the next cycle with no stall. A read outside the line stalls the processor for a programmable number of flash wait states plus one cycle. The line is then refilled from both banks and the requested word is returned.

The block also runs sector erase. One erase request clears the matching 8 KB sector in each bank, so it covers 16 KB of contiguous address space. The sequencer walks every row of that region and forces it to all ones. Reads are held off while it runs. The array is behavioural. An unerased location returns a fixed pattern computed from its address, and each row keeps one flag that records whether it has been erased.

Top module: `flash_prefetch_ctrl`

## Requirements
- R1: The processor address is a word address `rd_word` (byte address divided by 4). Bit 2 selects the bank (0 = even bank, byte offsets 0x00-0x0F of each 32-byte block; 1 = odd bank, offsets 0x10-0x1F). Bits 1:0 select the 32-bit lane inside the 128-bit bank word. The bits above bit 2 form the row, which is also the line tag.
- R2: An unerased 32-bit word at byte address A reads as `{16'hC0DE, A[15:0]}`.
- R3: A read is accepted on a rising edge where `rd_req` is high, `stall` is low and `erase_req` is low. Every accepted read produces exactly one `rd_valid` pulse.
- R4: An accepted read whose row matches the valid line raises `rd_valid` with the word in the next cycle, and `stall` stays low.
- R5: An accepted read that misses holds `stall` high for exactly ws+1 cycles. `rd_valid` comes in the cycle after `stall` falls. The line then holds both bank halves, so a read to the other half hits.
- R6: Writing `cfg_we` loads the wait-state count from `cfg_ws`. Values above 5 are stored as 5. The reset value is 5.
- R7: A configuration write or an accepted erase invalidates the line, so the next read to that line misses.
- R8: `erase_req` is accepted on an edge where `stall` is low, and it takes priority over a simultaneous `rd_req`. It clears rows of sector s in both banks, which is byte range s*16 KB to s*16 KB+16 KB-1. `erase_busy` and `stall` stay high for exactly SECTOR_BYTES/16 (512) cycles.
- R9: After an erase, every word of the erased range reads 0xFFFFFFFF. Words in other sectors keep their content.
- R10: An `erase_req` raised while `stall` is high is ignored, and so is an `rd_req` raised while an erase is busy. Neither produces `erase_busy` or `rd_valid`.
- R11: After reset, `stall`, `rd_valid` and `erase_busy` are low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request |
| rd_word | input | WORD_AW | Word address of the read |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| stall | output | 1 | Processor must hold off; requests are not accepted |
| cfg_we | input | 1 | Wait-state configuration write |
| cfg_ws | input | 3 | Wait-state count (clamped to 5) |
| erase_req | input | 1 | Sector erase request |
| erase_sector | input | SEC_W | Sector index to erase in both banks |
| erase_busy | output | 1 | Erase sequence running |

## Verification
The hardest situations to reach are the collisions: an erase request arriving in the middle of a miss stall, a read pulse landing inside the 512-cycle erase window, and a read and an erase asserted on the same edge. The bench reaches them by programming the largest wait-state count, which stretches the stall window. It then drives the colliding request on a chosen falling edge inside that window. Afterwards it reads both the erased sector and the neighbouring sector back through the normal read port, which shows what the ignored request could have disturbed.

// File: rtl/flash_pf_pkg.sv
package flash_pf_pkg;

  localparam int LANE_W   = 32;
  localparam int BANK_W   = 128;
  localparam int LINE_W   = 2 * BANK_W;
  localparam int LANES    = BANK_W / LANE_W;
  localparam logic [2:0] WS_MAX = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MISS  = 2'd1,
    ST_ERASE = 2'd2
  } seq_state_e;

  // Content of a never-erased location, derived from its byte address.
  function automatic logic [LANE_W-1:0] factory_word(input logic [15:0] byte_addr);
    return {16'hC0DE, byte_addr};
  endfunction

endpackage

// File: rtl/flash_pf_bank.sv
module flash_pf_bank
  import flash_pf_pkg::*;
#(
  parameter int   ROWS     = 1024,
  parameter int   ROW_W    = 10,
  parameter logic BANK_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [BANK_W-1:0] rd_data,
  input  logic              clr_en,
  input  logic [ROW_W-1:0]  clr_row
);

  logic [ROWS-1:0] erased_q;
  logic [ROWS-1:0] erased_d;

  always_comb begin
    erased_d = erased_q;
    if (clr_en) begin
      erased_d[clr_row] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erased_q <= '0;
    end else begin
      erased_q <= erased_d;
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [15:0] lane_addr;
      assign lane_addr = 16'({rd_row, BANK_SEL, 2'(l), 2'b00});
      assign rd_data[l*LANE_W +: LANE_W] =
        erased_q[rd_row] ? {LANE_W{1'b1}} : factory_word(lane_addr);
    end
  endgenerate

endmodule

// File: rtl/flash_pf_line.sv
module flash_pf_line
  import flash_pf_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval,
  input  logic              fill,
  input  logic [ROW_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic [2:0]        fill_sel,
  input  logic [ROW_W-1:0]  look_tag,
  input  logic [2:0]        look_sel,
  output logic              hit,
  output logic [LANE_W-1:0] look_word,
  output logic [LANE_W-1:0] fill_word
);

  logic              valid_q, valid_d;
  logic [ROW_W-1:0]  tag_q, tag_d;
  logic [LINE_W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    if (inval) begin
      valid_d = 1'b0;
    end else if (fill) begin
      valid_d = 1'b1;
    end
    if (fill) begin
      tag_d = fill_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      data_q <= fill_data;
    end
  end

  assign hit       = valid_q && (tag_q == look_tag);
  assign look_word = data_q[{look_sel, 5'b0} +: LANE_W];
  assign fill_word = fill_data[{fill_sel, 5'b0} +: LANE_W];

endmodule

// File: rtl/flash_pf_seq.sv
module flash_pf_seq
  import flash_pf_pkg::*;
#(
  parameter int WORD_AW  = 13,
  parameter int SEC_W    = 1,
  parameter int RPS      = 512,
  parameter int RPS_W    = 9,
  parameter int ROW_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [WORD_AW-1:0] rd_word,
  input  logic               hit,
  input  logic               erase_req,
  input  logic [SEC_W-1:0]   erase_sector,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_ws,
  output logic               stall,
  output logic               erase_busy,
  output logic               erase_go,
  output logic               hit_go,
  output logic               fill,
  output logic [WORD_AW-1:0] pend_word,
  output logic               clr_en,
  output logic [ROW_W-1:0]   clr_row
);

  seq_state_e         st_q, st_d;
  logic [2:0]         cnt_q, cnt_d;
  logic [2:0]         ws_q, ws_d;
  logic [WORD_AW-1:0] pend_q, pend_d;
  logic [SEC_W-1:0]   sec_q, sec_d;
  logic [RPS_W-1:0]   idx_q, idx_d;
  logic               idle, rd_go;

  assign idle     = (st_q == ST_IDLE);
  assign erase_go = erase_req && idle;
  assign rd_go    = rd_req && idle && !erase_req;
  assign hit_go   = rd_go && hit;
  assign fill     = (st_q == ST_MISS) && (cnt_q == 3'd0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    sec_d  = sec_q;
    idx_d  = idx_q;
    ws_d   = ws_q;
    if (cfg_we) begin
      ws_d = (cfg_ws > WS_MAX) ? WS_MAX : cfg_ws;
    end
    case (st_q)
      ST_IDLE: begin
        if (erase_go) begin
          st_d  = ST_ERASE;
          sec_d = erase_sector;
          idx_d = '0;
        end else if (rd_go && !hit) begin
          st_d   = ST_MISS;
          cnt_d  = ws_q;
          pend_d = rd_word;
        end
      end
      ST_MISS: begin
        if (cnt_q == 3'd0) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 3'd1;
        end
      end
      ST_ERASE: begin
        idx_d = idx_q + RPS_W'(1);
        if (idx_q == RPS_W'(RPS - 1)) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ws_q   <= WS_MAX;
      pend_q <= '0;
      sec_q  <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ws_q   <= ws_d;
      pend_q <= pend_d;
      sec_q  <= sec_d;
      idx_q  <= idx_d;
    end
  end

  assign stall      = !idle;
  assign erase_busy = (st_q == ST_ERASE);
  assign pend_word  = pend_q;
  assign clr_en     = erase_busy;
  assign clr_row    = {sec_q, idx_q};

endmodule

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl
  import flash_pf_pkg::*;
#(
  parameter int SECTOR_BYTES = 8192,
  parameter int SECTORS      = 2,
  parameter int WORD_AW      = $clog2(2 * SECTORS * SECTOR_BYTES) - 2,
  parameter int SEC_W        = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [WORD_AW-1:0] rd_word,
  output logic               rd_valid,
  output logic [LANE_W-1:0]  rd_data,
  output logic               stall,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_ws,
  input  logic               erase_req,
  input  logic [SEC_W-1:0]   erase_sector,
  output logic               erase_busy
);

  localparam int RPS   = SECTOR_BYTES / (BANK_W / 8);
  localparam int RPS_W = $clog2(RPS);
  localparam int ROWS  = SECTORS * RPS;
  localparam int ROW_W = WORD_AW - 3;

  logic               hit, hit_go, fill, erase_go, clr_en;
  logic [WORD_AW-1:0] pend_word;
  logic [ROW_W-1:0]   clr_row;
  logic [BANK_W-1:0]  bank_rd [2];
  logic [LINE_W-1:0]  fill_data;
  logic [LANE_W-1:0]  look_word, fill_word;
  logic               rd_valid_q, rd_valid_d;
  logic [LANE_W-1:0]  rd_data_q, rd_data_d;

  flash_pf_seq #(
    .WORD_AW(WORD_AW), .SEC_W(SEC_W), .RPS(RPS), .RPS_W(RPS_W), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_word(rd_word), .hit(hit),
    .erase_req(erase_req), .erase_sector(erase_sector),
    .cfg_we(cfg_we), .cfg_ws(cfg_ws),
    .stall(stall), .erase_busy(erase_busy), .erase_go(erase_go),
    .hit_go(hit_go), .fill(fill), .pend_word(pend_word),
    .clr_en(clr_en), .clr_row(clr_row)
  );

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      flash_pf_bank #(
        .ROWS(ROWS), .ROW_W(ROW_W), .BANK_SEL(1'(b))
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_row(pend_word[WORD_AW-1:3]), .rd_data(bank_rd[b]),
        .clr_en(clr_en), .clr_row(clr_row)
      );
    end
  endgenerate

  assign fill_data = {bank_rd[1], bank_rd[0]};

  flash_pf_line #(.ROW_W(ROW_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .inval(erase_go || cfg_we), .fill(fill),
    .fill_tag(pend_word[WORD_AW-1:3]), .fill_data(fill_data),
    .fill_sel(pend_word[2:0]),
    .look_tag(rd_word[WORD_AW-1:3]), .look_sel(rd_word[2:0]),
    .hit(hit), .look_word(look_word), .fill_word(fill_word)
  );

  always_comb begin
    rd_valid_d = hit_go || fill;
    rd_data_d  = rd_data_q;
    if (hit_go) begin
      rd_data_d = look_word;
    end else if (fill) begin
      rd_data_d = fill_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/flash_pf_checker.sv
module flash_pf_checker #(
  parameter int SECTOR_BYTES = 8192
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req,
  input logic       erase_req,
  input logic       cfg_we,
  input logic [2:0] cfg_ws,
  input logic       rd_valid,
  input logic       stall,
  input logic       erase_busy
);

  localparam int ERASE_CYC = SECTOR_BYTES / 16;

  logic [2:0]  ws_c;
  logic [2:0]  exp_q;
  logic [3:0]  len_q;
  logic [15:0] elen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_c   <= 3'd5;
      exp_q  <= '0;
      len_q  <= '0;
      elen_q <= '0;
    end else begin
      if (cfg_we) ws_c <= (cfg_ws > 3'd5) ? 3'd5 : cfg_ws;
      if (rd_req && !stall && !erase_req) begin
        exp_q <= ws_c;
        len_q <= '0;
      end else if (stall && !erase_busy) begin
        len_q <= len_q + 4'd1;
      end
      if (erase_req && !stall) elen_q <= '0;
      else if (erase_busy)     elen_q <= elen_q + 16'd1;
    end
  end

  // R4, R5: data is never presented while the port is stalled
  a_r4_valid_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !stall);

  // R3: an accepted read is answered at once or stalls
  a_r3_accept_responds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !stall && !erase_req) |=> (rd_valid || stall));

  // R5: a miss stall lasts ws+1 cycles and ends with data
  a_r5_miss_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && !$past(erase_busy)) |-> (rd_valid && (len_q == {1'b0, exp_q} + 4'd1)));

  // R8: an erase starts on acceptance
  a_r8_erase_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !stall) |=> erase_busy);

  // R8: the erase window has the exact length
  a_r8_erase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> (elen_q == 16'(ERASE_CYC)));

  // R10: reads are held off during erase
  a_r10_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (stall && !rd_valid));

endmodule

bind flash_prefetch_ctrl flash_pf_checker #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .erase_req(erase_req),
  .cfg_we(cfg_we), .cfg_ws(cfg_ws), .rd_valid(rd_valid), .stall(stall),
  .erase_busy(erase_busy)
);

// File: tb/flash_prefetch_ctrl_bench.sv
module flash_prefetch_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;
  localparam int WAW        = 13;

  logic           clk, rst_n;
  logic           rd_req, rd_valid, stall, cfg_we, erase_req, erase_busy;
  logic [WAW-1:0] rd_word;
  logic [31:0]    rd_data;
  logic [2:0]     cfg_ws;
  logic [0:0]     erase_sector;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] exp_q [$];
  string       exp_r [$];

  int ws_m     = 5;
  bit line_ok  = 0;
  int line_tag = 0;
  bit erased [2] = '{0, 0};

  flash_prefetch_ctrl u_flash_prefetch_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_word(rd_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .stall(stall),
    .cfg_we(cfg_we), .cfg_ws(cfg_ws), .erase_req(erase_req),
    .erase_sector(erase_sector), .erase_busy(erase_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [31:0] expw(input int w);
    if (erased[w >> 12]) return 32'hFFFF_FFFF;
    return {16'hC0DE, 16'(w << 2)};
  endfunction

  // monitor: pops scoreboard entries as the design answers
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected rd_valid", 32'(rd_data), 32'h0);
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = exp_r.pop_front();
        chk(rd_data == e, r, rd_data, e);
      end
    end
  end

  task automatic do_read(input int w, input string rq, input string rq_lat);
    bit hit;
    int st;
    while (stall) @(negedge clk);
    hit = line_ok && (line_tag == (w >> 3));
    exp_q.push_back(expw(w));
    exp_r.push_back(rq);
    rd_req  = 1'b1;
    rd_word = WAW'(w);
    @(negedge clk);
    rd_req = 1'b0;
    st = 0;
    while (!rd_valid) begin
      if (stall) st++;
      @(negedge clk);
    end
    chk(st == (hit ? 0 : ws_m + 1), rq_lat, 32'(st), 32'(hit ? 0 : ws_m + 1));
    line_ok  = 1;
    line_tag = w >> 3;
  endtask

  task automatic do_cfg(input int v);
    cfg_we = 1'b1;
    cfg_ws = 3'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    ws_m    = (v > 5) ? 5 : v;
    line_ok = 0;
  endtask

  task automatic do_erase(input int sec, input bit with_rd);
    int n, nv;
    while (stall) @(negedge clk);
    erase_req    = 1'b1;
    erase_sector = 1'(sec);
    if (with_rd) begin
      rd_req  = 1'b1;
      rd_word = WAW'(sec * 4096 + 9);
    end
    @(negedge clk);
    erase_req = 1'b0;
    rd_req    = 1'b0;
    n = 0;
    nv = 0;
    while (erase_busy) begin
      n++;
      if (rd_valid) nv++;
      if (n == 100) begin
        rd_req  = 1'b1;
        rd_word = WAW'(sec * 4096 + 17);
      end
      @(negedge clk);
      rd_req = 1'b0;
    end
    chk(n == 512, "R8 erase busy length", 32'(n), 32'd512);
    chk(nv == 0 && !rd_valid, "R10 read during erase ignored", 32'(nv), 32'd0);
    erased[sec] = 1;
    line_ok = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; rd_word = '0; cfg_we = 1'b0; cfg_ws = '0;
    erase_req = 1'b0; erase_sector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!stall, "R11 stall after reset", 32'(stall), 32'd0);
    chk(!rd_valid, "R11 rd_valid after reset", 32'(rd_valid), 32'd0);
    chk(!erase_busy, "R11 erase_busy after reset", 32'(erase_busy), 32'd0);
    chk(rd_data == 32'h0, "R11 rd_data after reset", rd_data, 32'h0);

    // R6 reset wait states = 5, R5 miss, R2 pattern
    do_read('h10, "R2 miss data even bank", "R6 reset ws miss latency");
    // R4 hit on the other bank half, R1 lane mapping
    do_read('h15, "R1 hit data odd bank lane1", "R4 hit no stall");
    do_read('h12, "R1 hit data even bank lane2", "R4 hit no stall even");
    // R7 config write invalidates
    do_cfg(0);
    do_read('h13, "R7 data after cfg write", "R7 miss after cfg ws0");
    do_read('h1C, "R5 miss data new line", "R5 miss latency ws0");
    do_read('h18, "R5 line filled both halves", "R5 hit after fill");
    // R6 clamp of 7 to 5
    do_cfg(7);
    do_read('h1FFF, "R2 top word data", "R6 clamp ws7 latency");
    do_cfg(3);
    do_read('h1000, "R2 sector1 data", "R5 miss latency ws3");

    // R10 erase request inside miss stall is ignored
    do_cfg(5);
    begin
      int seen;
      while (stall) @(negedge clk);
      exp_q.push_back(expw('h1008));
      exp_r.push_back("R10 miss data with erase collision");
      rd_req = 1'b1; rd_word = WAW'('h1008);
      @(negedge clk);
      rd_req = 1'b0;
      erase_req = 1'b1; erase_sector = 1'b1;
      @(negedge clk);
      erase_req = 1'b0;
      seen = 0;
      while (!rd_valid) begin
        if (erase_busy) seen++;
        @(negedge clk);
      end
      @(negedge clk);
      if (erase_busy) seen++;
      chk(seen == 0, "R10 erase during stall ignored", 32'(seen), 32'd0);
      line_ok = 1; line_tag = 'h1008 >> 3;
    end
    do_read('h1009, "R10 sector1 intact after ignored erase", "R4 hit after collision");

    // R8 erase sector 0 with simultaneous read (erase wins)
    do_erase(0, 1'b1);
    do_read('h0, "R9 erased word bank0", "R7 miss after erase");
    do_read('h7, "R9 erased word bank1 lane3", "R4 hit in erased line");
    do_read('hFFF, "R9 last erased word", "R5 miss last erased row");
    do_read('h1000, "R9 neighbour sector untouched", "R5 miss neighbour");

    // R7 erase invalidates an unrelated line
    do_read('h1004, "R2 sector1 line fill", "R4 hit existing line");
    do_erase(0, 1'b0);
    do_read('h1005, "R7 data after erase invalidation", "R7 miss after erase of other sector");
    do_read('h800, "R9 mid erased word", "R5 miss mid sector");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 every accepted read answered", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule